// File: doc/BRIEF.md
# Nibble-Serial Character Display Write Engine

This block writes one byte, either a command or a character, to a character display controller of the common 44780-compatible kind over a four-bit data bus. Each start strobe carries the byte, the register-select level and two options. The engine then sends the upper four bits and the lower four bits as two separate enable pulses, waits between them, and finally holds off for the display's execution time before it reports completion with a one-cycle done pulse.

All bus timings are given in nanoseconds and turned into clock-cycle counts from a clock-frequency parameter, so the same block works at any system clock. A single-nibble option sends only the upper four bits. This is used during the power-up sequence, where the display still expects eight-bit transfers. A long-wait option selects the longer execution delay that clear and return-home commands need. The engine only writes: the read/write line is held low, and the busy flag is never polled.

Top module: `lcdw_engine`

## Requirements
- R1: After a synchronous active-low reset, E, RS, the data nibble and done are all low, and the engine accepts a start in the next cycle.
- R2: RS and the data nibble take their new values on the clock edge that samples start. E rises exactly ceil(T_SETUP_NS*CLK_HZ/1e9) cycles later (minimum one cycle). The data lines do not change on the edge where E rises.
- R3: Each E pulse stays high for exactly ceil(T_EHIGH_NS*CLK_HZ/1e9) cycles.
- R4: The first E pulse carries byte bits 7:4 on the data nibble and the second carries bits 3:0. The upper half always goes first.
- R5: RS and the data nibble stay unchanged while E is high and for at least ceil(T_HOLD_NS*CLK_HZ/1e9) cycles after E falls.
- R6: In two-nibble mode, the second E rise comes hold + gap + setup cycles after the first E fall. The gap is ceil(T_GAP_NS*CLK_HZ/1e9) cycles, so the wait between nibbles is at least T_GAP_NS.
- R7: When the single-nibble option is 1, only one E pulse (bits 7:4) is produced, and the execution wait starts at its falling edge.
- R8: Done rises a fixed number of cycles after the last E falls. That number is ceil(T_EXEC_LONG_NS*CLK_HZ/1e9) when the long-wait option was 1 at start, and ceil(T_EXEC_SHORT_NS*CLK_HZ/1e9) otherwise. Each is raised to at least the E cycle-time count. E is low whenever done is high.
- R9: Done is high for exactly one clock cycle per accepted transfer.
- R10: A start strobe that arrives while a transfer is in progress is ignored. The byte, RS, options, pulse count and done timing of the running transfer are unchanged.
- R11: The read/write output is low at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, frequency given by CLK_HZ |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to write wr_byte |
| wr_byte | input | 8 | Command or character byte to write |
| wr_rs | input | 1 | Register select level for this byte (0 command, 1 data) |
| wr_single | input | 1 | 1 sends only bits 7:4 |
| wr_long | input | 1 | 1 selects the long execution wait |
| lcd_rs | output | 1 | Register select line to the display |
| lcd_rw | output | 1 | Read/write line, always low |
| lcd_e | output | 1 | Enable strobe to the display |
| lcd_db | output | 4 | Four-bit data bus to the display |
| done | output | 1 | One-cycle pulse when the execution wait ends |

## Verification
The engine is driven with a short command byte (0x28, RS low), a data byte with alternating bits (0xA5, RS high) and a clear-style byte with the long wait. Comparing these shows whether the nibble order and the RS level are right, and whether the two execution delays are told apart. A single-nibble transfer checks that the second pulse is dropped and that the wait starts at the first falling edge. A transfer hit by a second start carrying a different byte and RS level shows whether the stray strobe can corrupt the running write. A reset pulled in the middle of a transfer, followed by a clean write, checks that the bus returns to idle and that the engine recovers.

// File: rtl/lcdw_pkg.sv
// Package: shared state type and the nanosecond-to-cycle conversion
// used by the nibble-serial display write engine.
// Assumes: products of ns and clock frequency fit in 64 bits.
package lcdw_pkg;

    // One-hot state of the write sequence; order is the sequence order.
    typedef enum logic [6:0] {
        ST_HI_SET = 7'b0000001,  // upper nibble on bus, setup time, also idle
        ST_HI_EH  = 7'b0000010,  // E high for the upper nibble
        ST_HI_EL  = 7'b0000100,  // E low, hold of the upper nibble
        ST_GAP    = 7'b0001000,  // wait before the lower nibble
        ST_LO_SET = 7'b0010000,  // lower nibble on bus, setup time
        ST_LO_EH  = 7'b0100000,  // E high for the lower nibble
        ST_EXEC   = 7'b1000000   // E low, execution wait of the display
    } wr_state_e;

    // Round a duration up to whole clock cycles, never below one cycle.
    function automatic int unsigned ns_to_cycles(input longint unsigned ns,
                                                 input longint unsigned hz);
        longint unsigned prod;
        longint unsigned cyc;
        prod = ns * hz;
        cyc  = (prod + 64'd999_999_999) / 64'd1_000_000_000;
        if (cyc == 64'd0) cyc = 64'd1;
        return int'(cyc[31:0]);
    endfunction

    // Larger of two counts.
    function automatic int unsigned max_u(input int unsigned a,
                                          input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/lcdw_timer.sv
// Module: lcdw_timer
// Down-counter that times each state of the write sequence.
// Assumes: load_val is the wanted duration minus one; zero is high in the
// last cycle of that duration, and the count rests at zero until the next load.
module lcdw_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_q;

    // Load a new duration or count the current one down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

    // A count that is not being reloaded never rises.
    AST_TMR_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q == '0) |=> (cnt_q == '0));  // R3

endmodule

// File: rtl/lcdw_bus.sv
// Module: lcdw_bus
// Output registers for the display lines: register select, data nibble and
// enable. Every line comes straight from a flop, so nothing glitches.
// Assumes: the sequencer raises nib_load only while E is low.
module lcdw_bus (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       nib_load,
    input  logic [3:0] nib_val,
    input  logic       rs_load,
    input  logic       rs_val,
    input  logic       e_next,
    output logic       rs_o,
    output logic [3:0] db_o,
    output logic       e_o
);

    // Capture the nibble and the RS level when the sequencer presents new values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            db_o <= 4'h0;
            rs_o <= 1'b0;
        end else begin
            if (nib_load) db_o <= nib_val;
            if (rs_load)  rs_o <= rs_val;
        end
    end

    // Register the enable strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) e_o <= 1'b0;
        else        e_o <= e_next;
    end

    // The data never changes on an edge that leaves E high.
    AST_BUS_NO_LOAD_IN_E: assert property (@(posedge clk) disable iff (!rst_n)
        e_o |-> !nib_load);  // R5

endmodule

// File: rtl/lcdw_fsm.sv
// Module: lcdw_fsm
// Seven-state sequencer: upper-nibble setup, E high, E low, inter-nibble
// gap, lower-nibble setup, E high, execution wait. ST_HI_SET doubles as the
// idle state, and busy_q tells the two roles apart.
// Assumes: every count parameter is at least one.
module lcdw_fsm
    import lcdw_pkg::*;
#(
    parameter int unsigned CNT_W    = 16,
    parameter int unsigned N_SETUP  = 2,
    parameter int unsigned N_EHIGH  = 8,
    parameter int unsigned N_HOLD   = 1,
    parameter int unsigned N_GAP    = 33,
    parameter int unsigned N_SHORT  = 1320,
    parameter int unsigned N_LONG   = 54120
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [7:0]       wr_byte,
    input  logic             wr_rs,
    input  logic             wr_single,
    input  logic             wr_long,
    input  logic             tmr_zero,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             nib_load,
    output logic [3:0]       nib_val,
    output logic             rs_load,
    output logic             e_next,
    output logic             done_o
);

    localparam logic [CNT_W-1:0] L_SETUP = CNT_W'(N_SETUP - 1);
    localparam logic [CNT_W-1:0] L_EHIGH = CNT_W'(N_EHIGH - 1);
    localparam logic [CNT_W-1:0] L_HOLD  = CNT_W'(N_HOLD - 1);
    localparam logic [CNT_W-1:0] L_GAP   = CNT_W'(N_GAP - 1);
    localparam logic [CNT_W-1:0] L_SHORT = CNT_W'(N_SHORT - 1);
    localparam logic [CNT_W-1:0] L_LONG  = CNT_W'(N_LONG - 1);

    wr_state_e state_q, state_d;
    logic       busy_q;
    logic [7:0] byte_q;
    logic       single_q;
    logic       long_q;
    logic       accept;
    logic       finish;
    logic [CNT_W-1:0] exec_val;

    assign exec_val = long_q ? L_LONG : L_SHORT;

    // Next state, timer reload and bus loads for the current cycle.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        accept   = 1'b0;
        finish   = 1'b0;
        nib_load = 1'b0;
        nib_val  = byte_q[3:0];
        unique case (state_q)
            ST_HI_SET: begin
                if (!busy_q) begin
                    if (start) begin
                        accept   = 1'b1;
                        tmr_load = 1'b1;
                        tmr_val  = L_SETUP;
                        nib_load = 1'b1;
                        nib_val  = wr_byte[7:4];
                    end
                end else if (tmr_zero) begin
                    state_d  = ST_HI_EH;
                    tmr_load = 1'b1;
                    tmr_val  = L_EHIGH;
                end
            end
            ST_HI_EH: begin
                if (tmr_zero) begin
                    tmr_load = 1'b1;
                    if (single_q) begin
                        state_d = ST_EXEC;
                        tmr_val = exec_val;
                    end else begin
                        state_d = ST_HI_EL;
                        tmr_val = L_HOLD;
                    end
                end
            end
            ST_HI_EL: begin
                if (tmr_zero) begin
                    state_d  = ST_GAP;
                    tmr_load = 1'b1;
                    tmr_val  = L_GAP;
                end
            end
            ST_GAP: begin
                if (tmr_zero) begin
                    state_d  = ST_LO_SET;
                    tmr_load = 1'b1;
                    tmr_val  = L_SETUP;
                    nib_load = 1'b1;
                    nib_val  = byte_q[3:0];
                end
            end
            ST_LO_SET: begin
                if (tmr_zero) begin
                    state_d  = ST_LO_EH;
                    tmr_load = 1'b1;
                    tmr_val  = L_EHIGH;
                end
            end
            ST_LO_EH: begin
                if (tmr_zero) begin
                    state_d  = ST_EXEC;
                    tmr_load = 1'b1;
                    tmr_val  = exec_val;
                end
            end
            ST_EXEC: begin
                if (tmr_zero) begin
                    state_d = ST_HI_SET;
                    finish  = 1'b1;
                end
            end
            default: state_d = ST_HI_SET;
        endcase
    end

    assign rs_load = accept;
    assign e_next  = (state_d == ST_HI_EH) || (state_d == ST_LO_EH);

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HI_SET;
        else        state_q <= state_d;
    end

    // Busy flag and per-transfer options, captured only when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            byte_q   <= 8'h00;
            single_q <= 1'b0;
            long_q   <= 1'b0;
        end else if (accept) begin
            busy_q   <= 1'b1;
            byte_q   <= wr_byte;
            single_q <= wr_single;
            long_q   <= wr_long;
        end else if (finish) begin
            busy_q   <= 1'b0;
        end
    end

    // One-cycle completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) done_o <= 1'b0;
        else        done_o <= finish;
    end

    // Sequencer checks.
    logic past_ok;
    // Marks the cycles where $past refers to post-reset values.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    AST_STATE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(state_q) == 1);  // R4
    AST_LO_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && state_q == ST_LO_SET && $past(state_q) != ST_LO_SET)
            |-> $past(state_q) == ST_GAP);  // R6
    AST_BUSY_KEEPS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && start) |=> $stable(byte_q) && $stable(long_q) && $stable(single_q));  // R10
    AST_SINGLE_SKIPS_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && single_q) |-> state_q != ST_LO_EH);  // R7

endmodule

// File: rtl/lcdw_engine.sv
// Module: lcdw_engine (top)
// Writes one byte to a 44780-compatible character display over a four-bit
// bus as two enable-strobed nibbles, upper half first, then waits for the
// display's execution time and pulses done.
// Assumes: a start that comes while a transfer runs is dropped; callers
// wait for done. Every time parameter is in ns and is rounded up to cycles.
module lcdw_engine
    import lcdw_pkg::*;
#(
    parameter longint unsigned CLK_HZ          = 33_000_000,
    parameter longint unsigned T_SETUP_NS      = 40,
    parameter longint unsigned T_EHIGH_NS      = 230,
    parameter longint unsigned T_HOLD_NS       = 10,
    parameter longint unsigned T_CYCLE_NS      = 500,
    parameter longint unsigned T_GAP_NS        = 1_000,
    parameter longint unsigned T_EXEC_SHORT_NS = 40_000,
    parameter longint unsigned T_EXEC_LONG_NS  = 1_640_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] wr_byte,
    input  logic       wr_rs,
    input  logic       wr_single,
    input  logic       wr_long,
    output logic       lcd_rs,
    output logic       lcd_rw,
    output logic       lcd_e,
    output logic [3:0] lcd_db,
    output logic       done
);

    localparam int unsigned N_SETUP = ns_to_cycles(T_SETUP_NS, CLK_HZ);
    localparam int unsigned N_EHIGH = ns_to_cycles(T_EHIGH_NS, CLK_HZ);
    localparam int unsigned N_HOLD  = ns_to_cycles(T_HOLD_NS, CLK_HZ);
    localparam int unsigned N_CYC   = ns_to_cycles(T_CYCLE_NS, CLK_HZ);
    localparam int unsigned N_GAP   = ns_to_cycles(T_GAP_NS, CLK_HZ);
    localparam int unsigned N_SHORT = max_u(ns_to_cycles(T_EXEC_SHORT_NS, CLK_HZ), N_CYC);
    localparam int unsigned N_LONG  = max_u(ns_to_cycles(T_EXEC_LONG_NS, CLK_HZ), N_CYC);
    localparam int unsigned N_MAX   = max_u(max_u(N_LONG, N_SHORT),
                                            max_u(max_u(N_GAP, N_EHIGH), max_u(N_SETUP, N_HOLD)));
    localparam int unsigned CNT_W   = $clog2(N_MAX + 1);

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;
    logic             nib_load;
    logic [3:0]       nib_val;
    logic             rs_load;
    logic             e_next;

    lcdw_fsm #(
        .CNT_W   (CNT_W),
        .N_SETUP (N_SETUP),
        .N_EHIGH (N_EHIGH),
        .N_HOLD  (N_HOLD),
        .N_GAP   (N_GAP),
        .N_SHORT (N_SHORT),
        .N_LONG  (N_LONG)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .wr_byte   (wr_byte),
        .wr_rs     (wr_rs),
        .wr_single (wr_single),
        .wr_long   (wr_long),
        .tmr_zero  (tmr_zero),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .nib_load  (nib_load),
        .nib_val   (nib_val),
        .rs_load   (rs_load),
        .e_next    (e_next),
        .done_o    (done)
    );

    lcdw_timer #(
        .CNT_W (CNT_W)
    ) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    lcdw_bus u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .nib_load (nib_load),
        .nib_val  (nib_val),
        .rs_load  (rs_load),
        .rs_val   (wr_rs),
        .e_next   (e_next),
        .rs_o     (lcd_rs),
        .db_o     (lcd_db),
        .e_o      (lcd_e)
    );

    // Write-only engine.
    assign lcd_rw = 1'b0;

    logic past_ok;
    // Marks the cycles where $past refers to post-reset values.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    AST_DATA_HELD_IN_E: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && lcd_e && $past(lcd_e)) |-> ($stable(lcd_db) && $stable(lcd_rs)));  // R5
    AST_SETUP_BEFORE_E: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $rose(lcd_e)) |-> ($stable(lcd_db) && $stable(lcd_rs)));  // R2
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);  // R9
    AST_DONE_E_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !lcd_e);  // R8
    AST_RW_WITH_E: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_e |-> !lcd_rw);  // R11

endmodule

// File: tb/sim_lcdw_engine.sv
`timescale 1ns/1ps
// Directed bench for lcdw_engine at 125 MHz. Each task runs one scenario and
// checks its own results against counts worked out from the requirements.
module sim_lcdw_engine;

    localparam longint unsigned HZ = 125_000_000;
    localparam int PERIOD_NS = 8;

    // Expected cycle counts: round up to 8 ns steps, at least one.
    function automatic int tcyc(input int ns);
        int c;
        c = (ns + PERIOD_NS - 1) / PERIOD_NS;
        return (c < 1) ? 1 : c;
    endfunction

    localparam int SETUP_NS = 40, EH_NS = 230, HOLD_NS = 10, CYC_NS = 500;
    localparam int GAP_NS = 1000, SHORT_NS = 4000, LONG_NS = 20000;
    localparam int E_SET = tcyc(SETUP_NS);
    localparam int E_EH  = tcyc(EH_NS);
    localparam int E_HLD = tcyc(HOLD_NS);
    localparam int E_GAP = tcyc(GAP_NS);
    localparam int E_SH  = tcyc(SHORT_NS);
    localparam int E_LG  = tcyc(LONG_NS);

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] wr_byte = 8'h00;
    logic       wr_rs = 1'b0;
    logic       wr_single = 1'b0;
    logic       wr_long = 1'b0;
    wire        lcd_rs, lcd_rw, lcd_e, done;
    wire [3:0]  lcd_db;

    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk;

    lcdw_engine #(
        .CLK_HZ          (HZ),
        .T_SETUP_NS      (SETUP_NS),
        .T_EHIGH_NS      (EH_NS),
        .T_HOLD_NS       (HOLD_NS),
        .T_CYCLE_NS      (CYC_NS),
        .T_GAP_NS        (GAP_NS),
        .T_EXEC_SHORT_NS (SHORT_NS),
        .T_EXEC_LONG_NS  (LONG_NS)
    ) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .wr_byte   (wr_byte),
        .wr_rs     (wr_rs),
        .wr_single (wr_single),
        .wr_long   (wr_long),
        .lcd_rs    (lcd_rs),
        .lcd_rw    (lcd_rw),
        .lcd_e     (lcd_e),
        .lcd_db    (lcd_db),
        .done      (done)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One write. Optionally injects a stray start at sample index inj_at.
    task automatic run_xfer(input logic [7:0] b, input logic rs, input logic single,
                            input logic lng, input int inj_at,
                            input logic [7:0] inj_b, input logic inj_rs, input string tag);
        int rise1, fall1, rise2, fall2, done_at, done_cnt, rises;
        int db_r1, db_r2, rs_r1, rs_r2, bad_stable, bad_rw, last_fall, last_db;
        int exp_done, horizon, exec_n;
        logic prev_e;
        rise1 = -1; fall1 = -1; rise2 = -1; fall2 = -1; done_at = -1;
        done_cnt = 0; rises = 0; db_r1 = -1; db_r2 = -1; rs_r1 = -1; rs_r2 = -1;
        bad_stable = 0; bad_rw = 0; last_fall = -100; last_db = 0; prev_e = 1'b0;
        exec_n = lng ? E_LG : E_SH;
        if (single) exp_done = E_SET + E_EH + exec_n;
        else        exp_done = 2 * (E_SET + E_EH) + E_HLD + E_GAP + exec_n;
        horizon = exp_done + 25;
        @(negedge clk);
        start = 1'b1; wr_byte = b; wr_rs = rs; wr_single = single; wr_long = lng;
        for (int i = 0; i <= horizon; i++) begin
            @(negedge clk);
            if (i == 0) begin
                start = 1'b0; wr_byte = 8'h00; wr_rs = 1'b0; wr_single = 1'b0; wr_long = 1'b0;
            end
            if (i == inj_at) begin
                start = 1'b1; wr_byte = inj_b; wr_rs = inj_rs; wr_single = 1'b1; wr_long = 1'b1;
            end
            if (i == inj_at + 1) begin
                start = 1'b0; wr_byte = 8'h00; wr_rs = 1'b0; wr_single = 1'b0; wr_long = 1'b0;
            end
            if (lcd_rw !== 1'b0) bad_rw++;
            if (lcd_e && !prev_e) begin
                rises++;
                if (rises == 1) begin rise1 = i; db_r1 = lcd_db; rs_r1 = lcd_rs; end
                if (rises == 2) begin rise2 = i; db_r2 = lcd_db; rs_r2 = lcd_rs; end
                last_db = lcd_db;
            end
            if (lcd_e && prev_e && lcd_db != last_db) bad_stable++;
            if (!lcd_e && prev_e) begin
                last_fall = i;
                if (rises == 1) fall1 = i;
                if (rises == 2) fall2 = i;
            end
            if (!lcd_e && i < last_fall + E_HLD && lcd_db != last_db) bad_stable++;
            if (done) begin
                done_cnt++;
                if (done_at < 0) done_at = i;
                if (lcd_e) bad_stable++;
            end
            prev_e = lcd_e;
        end
        chk("R2", {tag, " first E rise"}, rise1, E_SET);
        chk("R2", {tag, " RS at first E rise"}, rs_r1, int'(rs));
        chk("R3", {tag, " first E fall"}, fall1, E_SET + E_EH);
        chk("R4", {tag, " nibble at first E"}, db_r1, int'(b[7:4]));
        chk("R5", {tag, " data/RS stability"}, bad_stable, 0);
        chk("R11", {tag, " RW high samples"}, bad_rw, 0);
        chk("R9", {tag, " done cycles"}, done_cnt, 1);
        chk("R8", {tag, " done time"}, done_at, exp_done);
        if (single) begin
            chk("R7", {tag, " E pulses"}, rises, 1);
        end else begin
            chk("R6", {tag, " second E rise"}, rise2, E_SET + E_EH + E_HLD + E_GAP + E_SET);
            chk("R3", {tag, " second E width"}, fall2 - rise2, E_EH);
            chk("R4", {tag, " nibble at second E"}, db_r2, int'(b[3:0]));
            chk("R10", {tag, " RS at second E"}, rs_r2, int'(rs));
            chk("R10", {tag, " E pulses"}, rises, 2);
        end
    endtask

    // R1: reset values and readiness.
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "E in reset", int'(lcd_e), 0);
        chk("R1", "RS in reset", int'(lcd_rs), 0);
        chk("R1", "DB in reset", int'(lcd_db), 0);
        chk("R1", "done in reset", int'(done), 0);
        chk("R11", "RW in reset", int'(lcd_rw), 0);
        rst_n = 1'b1;
    endtask

    // R1: reset in mid-transfer returns the bus to idle and the engine recovers.
    task automatic t_reset_mid();
        @(negedge clk);
        start = 1'b1; wr_byte = 8'hF7; wr_rs = 1'b1; wr_single = 1'b0; wr_long = 1'b0;
        @(negedge clk);
        start = 1'b0;
        repeat (E_SET + 3) @(negedge clk);
        chk("R1", "E high before mid reset", int'(lcd_e), 1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1", "E after mid reset", int'(lcd_e), 0);
        chk("R1", "DB after mid reset", int'(lcd_db), 0);
        chk("R1", "RS after mid reset", int'(lcd_rs), 0);
        run_xfer(8'h0C, 1'b0, 1'b0, 1'b0, -10, 8'h00, 1'b0, "after-reset");
    endtask

    initial begin
        t_reset();
        run_xfer(8'h28, 1'b0, 1'b0, 1'b0, -10, 8'h00, 1'b0, "cmd-short");
        run_xfer(8'hA5, 1'b1, 1'b0, 1'b0, -10, 8'h00, 1'b0, "data");
        run_xfer(8'h01, 1'b0, 1'b0, 1'b1, -10, 8'h00, 1'b0, "clear-long");
        run_xfer(8'h30, 1'b0, 1'b1, 1'b0, -10, 8'h00, 1'b0, "single");
        run_xfer(8'h5C, 1'b0, 1'b0, 1'b0, 100, 8'hFF, 1'b1, "stray-start");
        t_reset_mid();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(150_000 * PERIOD_NS);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule